// File: doc/BRIEF.md
# Tooth-Wheel Pulse Interval Meter

This block measures a single conditioned tooth-wheel pulse stream. The raw pulse input is brought into the system clock domain through a synchronizer chain, and each low-to-high transition becomes a one-cycle edge event. Two running counts are kept from these events. One counts edges per revolution and is cleared by an index strobe from a separate index-tooth detector. The other counts every edge since reset and is cleared only by reset.

The block also runs a measurement interval whose length is set in clock ticks by `ivl_ticks`. In timed mode, each interval produces the number of ticks from its first detected edge to its last, together with the number of edges seen in it. In window mode, it produces the number of edges in the interval together with the interval length. Both results are loaded into a pair of holding outputs in the same cycle, and a one-cycle strobe marks the update, so a reader always sees two values that belong together.

When no edge has arrived for `stall_ticks` consecutive cycles, the shaft counts as stalled. The revolution count and both holding outputs are cleared, and the interval stops. The next detected edge restarts the interval, with that edge as its first cycle. All counters saturate at their maximum value instead of wrapping.

Top module: `vr_edge_meter`

## Requirements
- R1: After reset, `rev_edges`, `total_edges`, `meas_a` and `meas_b` are all zero and `meas_valid` is low.
- R2: Each low-to-high transition of `pulse_in` in which each level is held for at least one clock period adds exactly one to `total_edges`. Neither `index_strobe` nor a stall clears `total_edges`.
- R3: `rev_edges` counts detected edges and returns to zero one cycle after `index_strobe` is high, or to one if an edge is detected in that same cycle.
- R4: While not stalled, `meas_valid` pulses for one cycle once every `ivl_ticks` cycles (a value of 0 is treated as 1). After a stall, the first interval starts in the cycle in which the first new edge is detected.
- R5: Timed mode (`mode_sel` = 0): at each update, `meas_b` is the number of edges detected in the interval. `meas_a` is the number of clock ticks from the first to the last of those edges, or 0 if there were fewer than two.
- R6: Window mode (`mode_sel` = 1): at each update, `meas_a` is the number of edges detected in the interval and `meas_b` equals the interval length `ivl_ticks`.
- R7: After `stall_ticks` consecutive cycles with no detected edge (`stall_ticks` = 0 disables this), `rev_edges`, `meas_a` and `meas_b` become zero, and `meas_valid` stays low until edges resume.
- R8: `total_edges` and `rev_edges` stop at 2^CNT_W-1 and never wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock (66 MHz nominal) |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| pulse_in | input | 1 | Conditioned tooth pulse, asynchronous to clk |
| index_strobe | input | 1 | One-cycle index-tooth strobe, synchronous to clk |
| mode_sel | input | 1 | 0 = timed span, 1 = pulses per window |
| ivl_ticks | input | CNT_W | Measurement interval length in clock ticks |
| stall_ticks | input | CNT_W | Edge-free cycles that declare a stall; 0 disables |
| rev_edges | output | CNT_W | Edges since the last index strobe or stall |
| total_edges | output | CNT_W | Edges since reset |
| meas_a | output | CNT_W | Timed: first-to-last span; window: edge count |
| meas_b | output | CNT_W | Timed: edge count; window: interval length |
| meas_valid | output | 1 | One-cycle strobe when meas_a and meas_b update |

## Verification
A fault in the interval phase shows up within one interval. Edges are then assigned to the wrong window, which changes the edge count and span pair at the next strobe, or the gap between strobes moves away from `ivl_ticks`. A fault in the span counter shows up in the first timed interval that holds two or more edges. A stall monitor that fires too early or too late shifts where the next interval starts, and every pair reported afterwards is wrong. It also leaves `rev_edges` nonzero at a point where the index test expects zero.

// File: rtl/vr_meter_pkg.sv
package vr_meter_pkg;
  typedef enum logic {
    MODE_TIMED  = 1'b0,
    MODE_WINDOW = 1'b1
  } meas_mode_e;
endpackage

// File: rtl/vr_edge_sync.sv
// Synchronizer chain followed by a rising-edge detector.
module vr_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  logic [STAGES-1:0] chain_q, chain_d;
  logic              last_q, last_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], din};
    last_d  = chain_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      last_q  <= 1'b0;
    end else begin
      chain_q <= chain_d;
      last_q  <= last_d;
    end
  end

  assign rise = chain_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/vr_stall_mon.sv
// Counts edge-free cycles and flags a stall when the limit is reached.
module vr_stall_mon #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rise,
  input  logic [W-1:0] limit,
  output logic         stall_hit,
  output logic         stalled
);
  logic [W-1:0] idle_q, idle_d;
  logic         stalled_q, stalled_d;

  always_comb begin
    stall_hit = (limit != '0) && !rise && !stalled_q && (idle_q == limit - 1'b1);
    idle_d    = idle_q;
    stalled_d = stalled_q;
    if (rise) begin
      idle_d    = '0;
      stalled_d = 1'b0;
    end else begin
      if (stall_hit) stalled_d = 1'b1;
      if (!stalled_q && idle_q != '1) idle_d = idle_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_q    <= '0;
      stalled_q <= 1'b0;
    end else begin
      idle_q    <= idle_d;
      stalled_q <= stalled_d;
    end
  end

  assign stalled = stalled_q;
endmodule

// File: rtl/vr_interval_meas.sv
// Interval timer, first-to-last span tracking and paired result registers.
module vr_interval_meas
  import vr_meter_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rise,
  input  logic         stall_hit,
  input  logic         stalled,
  input  meas_mode_e   mode,
  input  logic [W-1:0] ivl_ticks,
  output logic [W-1:0] res_a,
  output logic [W-1:0] res_b,
  output logic         res_valid
);
  logic [W-1:0] win_q, win_d, run_q, run_d, last_q, last_d, cnt_q, cnt_d;
  logic [W-1:0] a_q, a_d, b_q, b_d;
  logic         started_q, started_d, valid_q, valid_d;
  logic [W-1:0] len_eff, span_now, edges_now, run_inc;
  logic         active, term;

  // Values as they would stand if the current cycle closed the interval.
  always_comb begin
    len_eff   = (ivl_ticks == '0) ? {{(W-1){1'b0}}, 1'b1} : ivl_ticks;
    active    = !stalled || rise;
    term      = active && (win_q == len_eff - 1'b1);
    run_inc   = (run_q == '1) ? run_q : run_q + 1'b1;
    span_now  = rise ? (started_q ? run_q : '0) : last_q;
    edges_now = (rise && cnt_q != '1) ? cnt_q + 1'b1 : cnt_q;
  end

  always_comb begin
    win_d     = win_q;
    run_d     = run_q;
    last_d    = last_q;
    cnt_d     = cnt_q;
    started_d = started_q;
    a_d       = a_q;
    b_d       = b_q;
    valid_d   = 1'b0;
    if (stall_hit) begin
      win_d = '0; run_d = '0; last_d = '0; cnt_d = '0; started_d = 1'b0;
      a_d   = '0; b_d   = '0;
    end else if (term) begin
      if (mode == MODE_WINDOW) begin
        a_d = edges_now;
        b_d = len_eff;
      end else begin
        a_d = span_now;
        b_d = edges_now;
      end
      valid_d = 1'b1;
      win_d = '0; run_d = '0; last_d = '0; cnt_d = '0; started_d = 1'b0;
    end else if (active) begin
      win_d = win_q + 1'b1;
      if (rise) begin
        cnt_d     = edges_now;
        last_d    = span_now;
        started_d = 1'b1;
        run_d     = started_q ? run_inc : {{(W-1){1'b0}}, 1'b1};
      end else if (started_q) begin
        run_d = run_inc;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q     <= '0;
      run_q     <= '0;
      last_q    <= '0;
      cnt_q     <= '0;
      started_q <= 1'b0;
      a_q       <= '0;
      b_q       <= '0;
      valid_q   <= 1'b0;
    end else begin
      win_q     <= win_d;
      run_q     <= run_d;
      last_q    <= last_d;
      cnt_q     <= cnt_d;
      started_q <= started_d;
      a_q       <= a_d;
      b_q       <= b_d;
      valid_q   <= valid_d;
    end
  end

  assign res_a     = a_q;
  assign res_b     = b_q;
  assign res_valid = valid_q;
endmodule

// File: rtl/vr_edge_meter.sv
// Top: edge counters plus interval measurement and stall handling.
module vr_edge_meter
  import vr_meter_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pulse_in,
  input  logic             index_strobe,
  input  logic             mode_sel,
  input  logic [CNT_W-1:0] ivl_ticks,
  input  logic [CNT_W-1:0] stall_ticks,
  output logic [CNT_W-1:0] rev_edges,
  output logic [CNT_W-1:0] total_edges,
  output logic [CNT_W-1:0] meas_a,
  output logic [CNT_W-1:0] meas_b,
  output logic             meas_valid
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic             rise, stall_hit, stalled;
  logic [CNT_W-1:0] rev_q, rev_d, tot_q, tot_d;
  meas_mode_e       mode;

  assign mode = meas_mode_e'(mode_sel);

  vr_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(pulse_in), .rise(rise)
  );

  vr_stall_mon #(.W(CNT_W)) u_stall (
    .clk(clk), .rst_n(rst_n), .rise(rise), .limit(stall_ticks),
    .stall_hit(stall_hit), .stalled(stalled)
  );

  vr_interval_meas #(.W(CNT_W)) u_meas (
    .clk(clk), .rst_n(rst_n), .rise(rise), .stall_hit(stall_hit),
    .stalled(stalled), .mode(mode), .ivl_ticks(ivl_ticks),
    .res_a(meas_a), .res_b(meas_b), .res_valid(meas_valid)
  );

  // Index strobe wins over counting; an edge in the same cycle starts the new revolution.
  always_comb begin
    rev_d = rev_q;
    if (stall_hit)                rev_d = '0;
    else if (index_strobe)        rev_d = rise ? ONE : '0;
    else if (rise && rev_q != '1) rev_d = rev_q + 1'b1;
    tot_d = (rise && tot_q != '1) ? tot_q + 1'b1 : tot_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rev_q <= '0;
      tot_q <= '0;
    end else begin
      rev_q <= rev_d;
      tot_q <= tot_d;
    end
  end

  assign rev_edges   = rev_q;
  assign total_edges = tot_q;
endmodule

// File: rtl/vr_edge_meter_chk.sv
module vr_edge_meter_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         index_strobe,
  input logic         mode_sel,
  input logic [W-1:0] ivl_ticks,
  input logic [W-1:0] rev_edges,
  input logic [W-1:0] total_edges,
  input logic [W-1:0] meas_a,
  input logic [W-1:0] meas_b,
  input logic         meas_valid
);
  p_total_monotone_r2: assert property (@(posedge clk) disable iff (!rst_n)
    total_edges >= $past(total_edges));

  p_index_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    index_strobe |=> (rev_edges <= 1));

  p_valid_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (meas_valid && ivl_ticks > 1 && $stable(ivl_ticks)) |=> !meas_valid);

  p_timed_short_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (meas_valid && !$past(mode_sel) && meas_b < 2) |-> (meas_a == '0));

  p_window_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (meas_valid && $past(mode_sel) && $past(ivl_ticks) != '0) |-> (meas_b == $past(ivl_ticks)));

  p_hold_change_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (meas_a != $past(meas_a)) |-> (meas_valid || (meas_a == '0 && meas_b == '0 && rev_edges == '0)));

  p_total_sat_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (total_edges == '1) |=> (total_edges == '1));
endmodule

bind vr_edge_meter vr_edge_meter_chk #(.W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .index_strobe(index_strobe), .mode_sel(mode_sel),
  .ivl_ticks(ivl_ticks), .rev_edges(rev_edges), .total_edges(total_edges),
  .meas_a(meas_a), .meas_b(meas_b), .meas_valid(meas_valid)
);

// File: tb/sim_vr_edge_meter.sv
module sim_vr_edge_meter;
  localparam int CLK_PERIOD = 10;
  localparam int W     = 8;
  localparam int L     = 20;
  localparam int LIMIT = 30;
  localparam int MAXV  = (1 << W) - 1;

  logic         clk, rst_n, pulse_in, index_strobe, mode_sel;
  logic [W-1:0] ivl_ticks, stall_ticks;
  logic [W-1:0] rev_edges, total_edges, meas_a, meas_b;
  logic         meas_valid;

  int n_tests, n_fail, cyc, cap_n, exp_total;
  int cap_a [0:63];
  int cap_b [0:63];
  int cap_t [0:63];
  int pat   [0:63];
  int pat_n;

  vr_edge_meter #(.CNT_W(W), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .pulse_in(pulse_in), .index_strobe(index_strobe),
    .mode_sel(mode_sel), .ivl_ticks(ivl_ticks), .stall_ticks(stall_ticks),
    .rev_edges(rev_edges), .total_edges(total_edges), .meas_a(meas_a),
    .meas_b(meas_b), .meas_valid(meas_valid)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Capture strobed results a quarter period after the edge.
  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    cyc++;
    if (meas_valid && cap_n < 64) begin
      cap_a[cap_n] = int'(meas_a);
      cap_b[cap_n] = int'(meas_b);
      cap_t[cap_n] = cyc;
      cap_n++;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pulses(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      pulse_in = 1'b1;
      @(negedge clk);
      pulse_in = 1'b0;
      repeat (gap - 1) @(negedge clk);
    end
    repeat (5) @(negedge clk);
  endtask

  task automatic run_pattern(input logic md);
    int t;
    int cnt, first, last, ea, eb;
    mode_sel = md;
    repeat (LIMIT + 10) @(negedge clk);
    cap_n = 0;
    t = 0;
    for (int i = 0; i < pat_n; i++) begin
      while (t < pat[i]) begin @(negedge clk); t++; end
      pulse_in = 1'b1;
      @(negedge clk); t++;
      pulse_in = 1'b0;
    end
    while (t < 3 * L + 8) begin @(negedge clk); t++; end
    exp_total = (exp_total + pat_n > MAXV) ? MAXV : exp_total + pat_n;
    check(int'(total_edges) == exp_total, "R2 total", int'(total_edges), exp_total);
    check(cap_n >= 3, "R4 strobe count", cap_n, 3);
    if (cap_n >= 3) begin
      for (int k = 1; k < 3; k++)
        check(cap_t[k] - cap_t[k-1] == L, "R4 spacing", cap_t[k] - cap_t[k-1], L);
      for (int k = 0; k < 3; k++) begin
        cnt = 0; first = 0; last = 0;
        for (int i = 0; i < pat_n; i++)
          if (pat[i] >= k * L && pat[i] < (k + 1) * L) begin
            if (cnt == 0) first = pat[i];
            last = pat[i];
            cnt++;
          end
        if (md) begin
          ea = cnt; eb = L;
          check(cap_a[k] == ea, "R6 count", cap_a[k], ea);
          check(cap_b[k] == eb, "R6 length", cap_b[k], eb);
        end else begin
          ea = (cnt < 2) ? 0 : last - first; eb = cnt;
          check(cap_a[k] == ea, "R5 span", cap_a[k], ea);
          check(cap_b[k] == eb, "R5 count", cap_b[k], eb);
        end
      end
    end
  endtask

  initial begin
    n_tests = 0; n_fail = 0; cyc = 0; cap_n = 0; exp_total = 0;
    rst_n = 1'b0; pulse_in = 1'b0; index_strobe = 1'b0; mode_sel = 1'b0;
    ivl_ticks = W'(L); stall_ticks = W'(LIMIT);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(rev_edges == '0,   "R1 rev",   int'(rev_edges), 0);
    check(total_edges == '0, "R1 total", int'(total_edges), 0);
    check(meas_a == '0 && meas_b == '0, "R1 meas", int'(meas_a) + int'(meas_b), 0);
    check(!meas_valid,       "R1 valid", int'(meas_valid), 0);

    // Uniform pulse trains, every gap from 2 to 9, both modes (R4, R5, R6).
    for (int g = 2; g <= 9; g++) begin
      pat_n = 0;
      for (int o = 0; o < 3 * L; o += g) begin pat[pat_n] = o; pat_n++; end
      run_pattern(1'b0);
      run_pattern(1'b1);
    end

    // Irregular gaps (R5).
    pat_n = 9;
    pat[0] = 0;  pat[1] = 2;  pat[2] = 7;  pat[3] = 18; pat[4] = 22;
    pat[5] = 39; pat[6] = 41; pat[7] = 45; pat[8] = 58;
    run_pattern(1'b0);

    // Single edges in a window give span 0 (R5).
    pat_n = 4;
    pat[0] = 5; pat[1] = 30; pat[2] = 45; pat[3] = 50;
    run_pattern(1'b0);

    // Stall: results and revolution count cleared, no strobes (R7).
    repeat (LIMIT + 15) @(negedge clk);
    check(meas_a == '0 && meas_b == '0, "R7 meas cleared", int'(meas_a) + int'(meas_b), 0);
    check(rev_edges == '0, "R7 rev cleared", int'(rev_edges), 0);
    check(int'(total_edges) == exp_total, "R2 total kept on stall", int'(total_edges), exp_total);
    cap_n = 0;
    repeat (100) @(negedge clk);
    check(cap_n == 0, "R7 no strobe while stalled", cap_n, 0);

    // Index strobe clears revolution count only (R3, R2).
    pulses(5, 3);
    check(rev_edges == 8'd5, "R3 rev count", int'(rev_edges), 5);
    index_strobe = 1'b1;
    @(negedge clk);
    index_strobe = 1'b0;
    repeat (3) @(negedge clk);
    check(rev_edges == '0, "R3 index clear", int'(rev_edges), 0);
    exp_total += 5;
    check(int'(total_edges) == exp_total, "R2 total kept on index", int'(total_edges), exp_total);
    pulses(3, 3);
    exp_total += 3;
    check(rev_edges == 8'd3, "R3 rev after index", int'(rev_edges), 3);

    // Saturation (R8).
    pulses(300, 2);
    check(int'(total_edges) == MAXV, "R8 total sat", int'(total_edges), MAXV);
    check(int'(rev_edges) == MAXV,   "R8 rev sat",   int'(rev_edges), MAXV);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule